// File: doc/BRIEF.md
# Sign-Guarded Message Lane Link

This block carries the messages of one check node across a timing-critical hop, such as a permutation network between node processors. Each message is in sign-magnitude form: one sign bit and a magnitude field. The magnitude is sent once. The sign is sent twice. The second copy is XORed with a phase bit that flips on every enabled clock cycle. A register stage stands in for the network hop.

On the far side, the receiver removes the phase from the second copy and compares it with the primary sign. A word that arrives corrupted in its sign is caught. So is a word that arrives one cycle stale because of a late capture. When any lane of the node disagrees, the receiver punctures the node: every output message is forced to zero in that same cycle, and a node-level puncture request is raised. A registered error pulse, one bit per lane, follows one cycle later.

The encoded lanes leave the block on `lane_o`. The receiver reads `lane_i`. In normal use the two are tied together, possibly through routing logic. A single phase flip-flop serves both ends. The receiver decodes with the phase value that was in force when the word was captured, because the hop has a latency of exactly one register.

Top module: `sign_guard_link`

## Requirements
- R1: During and right after reset, every lane word on `lane_o` is 7'b0100000: sign 0, redundant bit 1, magnitude 0. The phase is 0. With `lane_i` tied to `lane_o`, the message outputs, `punct_o` and `err_o` are all 0.
- R2: Each lane word is 7 bits wide, with bit 6 the sign, bit 5 the redundant sign and bits 4:0 the magnitude. On an edge where `en_i` is high, each word captures the lane's input sign and magnitude. The redundant bit equals the sign on the odd-numbered enabled edges since reset and the inverted sign on the even-numbered ones.
- R3: On an edge where `en_i` is low, the lane words and the phase hold their values. The alternation of R2 then resumes with the next enabled edge.
- R4: When every lane of `lane_i` carries a consistent current word, `rx_sign_o` and `rx_mag_o` equal its sign and magnitude, and `punct_o` is 0.
- R5: If the sign check fails on any lane, `punct_o` is 1 and every lane's `rx_sign_o` and `rx_mag_o` are 0 in that same cycle. A lane fails when it carries a flipped sign or redundant bit, or when it repeats the word from the previous enabled cycle.
- R6: `err_o` bit k is 1 for exactly the cycle after lane k fails its check and is 0 otherwise. The bits of several failing lanes rise together.
- R7: The magnitude is not protected. A corrupted magnitude bit passes to `rx_mag_o` unchanged, with no puncture and no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enables a capture into the hop register and a phase flip |
| tx_sign_i | input | LANES | Sign of each message sent |
| tx_mag_i | input | LANES*MAG_W | Magnitude of each message sent, lane k at bits k*MAG_W upward |
| lane_o | output | LANES*(MAG_W+2) | Encoded lane words after the hop register |
| lane_i | input | LANES*(MAG_W+2) | Encoded lane words arriving at the receiver |
| rx_sign_o | output | LANES | Received sign, zero when punctured |
| rx_mag_o | output | LANES*MAG_W | Received magnitude, zero when punctured |
| punct_o | output | 1 | Node puncture request, same cycle as detection |
| err_o | output | LANES | Registered per-lane error pulse |

## Verification
The bench's main corner case is a stale word that repeats the previous enabled cycle's value with an unchanged sign. A receiver that decoded with the current phase, or a plain duplicate sign bit, would pass that word through silently. Pauses in `en_i` check that the phase does not drift relative to the held word; a phase that kept flipping would puncture clean traffic. Faults on one lane must zero all lanes, not only the faulty one. The error pulse must land one cycle late on the correct bits. A corrupted magnitude must pass through without a false puncture.

// File: rtl/slg_pkg.sv
package slg_pkg;
    parameter int MAG_W  = 5;
    localparam int WORD_W = MAG_W + 2;
    localparam int SIGN_BIT = MAG_W + 1;
    localparam int RED_BIT  = MAG_W;

    typedef struct packed {
        logic             sign;
        logic             red;
        logic [MAG_W-1:0] mag;
    } lane_word_t;

    localparam lane_word_t IDLE_WORD = '{sign: 1'b0, red: 1'b1, mag: '0};
endpackage

// File: rtl/slg_phase.sv
module slg_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic phase_o
);
    typedef struct packed {
        logic phase;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) st_d.phase = ~st_q.phase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_o = st_q.phase;

    // R2: phase flips on every enabled edge
    a_r2_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> (phase_o != $past(phase_o)));
    // R3: phase holds while disabled
    a_r3_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(phase_o));
endmodule

// File: rtl/slg_tx.sv
module slg_tx
    import slg_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    phase_i,
    input  logic [LANES-1:0]        sign_i,
    input  logic [LANES*MAG_W-1:0]  mag_i,
    output logic [LANES*WORD_W-1:0] word_o
);
    for (genvar k = 0; k < LANES; k++) begin : g_enc
        lane_word_t w;
        always_comb begin
            w.sign = sign_i[k];
            w.red  = sign_i[k] ^ phase_i;
            w.mag  = mag_i[k*MAG_W +: MAG_W];
        end
        assign word_o[k*WORD_W +: WORD_W] = w;
    end
endmodule

// File: rtl/slg_rx.sv
module slg_rx
    import slg_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    phase_i,
    input  logic [LANES*WORD_W-1:0] word_i,
    output logic [LANES-1:0]        sign_o,
    output logic [LANES*MAG_W-1:0]  mag_o,
    output logic                    punct_o,
    output logic [LANES-1:0]        err_o
);
    typedef struct packed {
        logic [LANES-1:0] err;
    } rx_state_t;

    rx_state_t        st_d, st_q;
    logic [LANES-1:0] bad;
    logic             punct;

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            lane_word_t w;
            w      = word_i[k*WORD_W +: WORD_W];
            bad[k] = w.sign ^ (w.red ^ phase_i);
        end
        punct    = |bad;
        st_d.err = bad;
        for (int k = 0; k < LANES; k++) begin
            lane_word_t w;
            w = word_i[k*WORD_W +: WORD_W];
            sign_o[k]                = punct ? 1'b0 : w.sign;
            mag_o[k*MAG_W +: MAG_W]  = punct ? '0 : w.mag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign punct_o = punct;
    assign err_o   = st_q.err;

    // R6: any error pulse follows a puncture one cycle earlier
    a_r6_err_after_punct: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_o) |-> $past(punct_o));
    // R6: a puncture always yields a pulse next cycle
    a_r6_punct_gives_err: assert property (@(posedge clk) disable iff (!rst_n)
        punct_o |=> (|err_o));
endmodule

// File: rtl/sign_guard_link.sv
module sign_guard_link
    import slg_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic [LANES-1:0]        tx_sign_i,
    input  logic [LANES*MAG_W-1:0]  tx_mag_i,
    output logic [LANES*WORD_W-1:0] lane_o,
    input  logic [LANES*WORD_W-1:0] lane_i,
    output logic [LANES-1:0]        rx_sign_o,
    output logic [LANES*MAG_W-1:0]  rx_mag_o,
    output logic                    punct_o,
    output logic [LANES-1:0]        err_o
);
    localparam int BUS_W = LANES * WORD_W;

    typedef struct packed {
        logic [BUS_W-1:0] lanes;
    } hop_state_t;

    hop_state_t       hop_d, hop_q;
    logic             phase;
    logic [BUS_W-1:0] enc_words;

    slg_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .phase_o (phase)
    );

    slg_tx #(.LANES(LANES)) u_tx (
        .phase_i (phase),
        .sign_i  (tx_sign_i),
        .mag_i   (tx_mag_i),
        .word_o  (enc_words)
    );

    always_comb begin
        hop_d = hop_q;
        if (en_i) hop_d.lanes = enc_words;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hop_q.lanes <= {LANES{IDLE_WORD}};
        else        hop_q <= hop_d;
    end

    assign lane_o = hop_q.lanes;

    // the receiver decodes with the phase in force at capture time
    slg_rx #(.LANES(LANES)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (~phase),
        .word_i  (lane_i),
        .sign_o  (rx_sign_o),
        .mag_o   (rx_mag_o),
        .punct_o (punct_o),
        .err_o   (err_o)
    );

    // R3: hop register holds while disabled
    a_r3_hop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(lane_o));
    // R5: a puncture clears every message output
    a_r5_zero_on_punct: assert property (@(posedge clk) disable iff (!rst_n)
        punct_o |-> (rx_sign_o == '0 && rx_mag_o == '0));

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        // R2: redundant bit carries the sign XOR the phase before the edge
        a_r2_red_bit: assert property (@(posedge clk) disable iff (!rst_n)
            en_i |=> (lane_o[k*WORD_W + RED_BIT] ==
                      (lane_o[k*WORD_W + SIGN_BIT] ^ $past(phase))));
    end
endmodule

// File: tb/tb_sign_guard_link.sv
module tb_sign_guard_link;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 4;
    localparam int MW = 5;
    localparam int WW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_i = 1'b0;
    logic [LANES-1:0] s_in = '0;
    logic [LANES*MW-1:0] m_in = '0;
    logic [LANES*WW-1:0] lane_o, lane_i;
    logic [LANES-1:0] rx_sign_o, err_o;
    logic [LANES*MW-1:0] rx_mag_o;
    logic punct_o;

    logic [LANES*WW-1:0] flip = '0;
    logic [LANES*WW-1:0] ovr = '0;
    logic use_ovr = 1'b0;
    assign lane_i = use_ovr ? ovr : (lane_o ^ flip);

    int n_chk = 0;
    int n_err = 0;
    int nen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sign_guard_link #(.LANES(LANES)) dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i),
        .tx_sign_i(s_in), .tx_mag_i(m_in),
        .lane_o(lane_o), .lane_i(lane_i),
        .rx_sign_o(rx_sign_o), .rx_mag_o(rx_mag_o),
        .punct_o(punct_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic en, input logic [LANES-1:0] s, input logic [LANES*MW-1:0] m);
        @(negedge clk);
        en_i = en; s_in = s; m_in = m;
        @(posedge clk);
        if (en) nen++;
        #1;
    endtask

    function automatic logic [LANES*WW-1:0] exp_bus(input logic [LANES-1:0] s, input logic [LANES*MW-1:0] m);
        logic [LANES*WW-1:0] b;
        for (int k = 0; k < LANES; k++)
            b[k*WW +: WW] = {s[k], s[k] ^ (nen % 2 == 0), m[k*MW +: MW]};
        return b;
    endfunction

    task automatic check_clean(input logic [LANES-1:0] s, input logic [LANES*MW-1:0] m, input string req);
        logic [LANES*WW-1:0] e;
        e = exp_bus(s, m);
        chk(lane_o == e, {req, " R2 lane word"}, 64'(lane_o), 64'(e));
        chk(rx_sign_o == s, {req, " R4 sign"}, 64'(rx_sign_o), 64'(s));
        chk(rx_mag_o == m, {req, " R4 mag"}, 64'(rx_mag_o), 64'(m));
        chk(punct_o == 1'b0, {req, " R4 no puncture"}, 64'(punct_o), 64'd0);
    endtask

    task automatic t_reset;
        chk(lane_o == {LANES{7'b0100000}}, "R1 idle words", 64'(lane_o), 64'({LANES{7'b0100000}}));
        chk(rx_sign_o == '0 && rx_mag_o == '0, "R1 outputs zero", 64'(rx_mag_o), 64'd0);
        chk(punct_o == 1'b0 && err_o == '0, "R1 no error", 64'({punct_o, err_o}), 64'd0);
    endtask

    task automatic t_patterns;
        step(1, 4'b1010, {5'd31, 5'd0, 5'd17, 5'd5});
        check_clean(4'b1010, {5'd31, 5'd0, 5'd17, 5'd5}, "pat1");
        step(1, 4'b1010, {5'd31, 5'd0, 5'd17, 5'd5});
        check_clean(4'b1010, {5'd31, 5'd0, 5'd17, 5'd5}, "pat2");
        step(1, 4'b0101, {5'd1, 5'd30, 5'd8, 5'd16});
        check_clean(4'b0101, {5'd1, 5'd30, 5'd8, 5'd16}, "pat3");
        chk(err_o == '0, "R6 no pulse on clean traffic", 64'(err_o), 64'd0);
    endtask

    task automatic t_hold;
        logic [LANES*WW-1:0] held;
        held = lane_o;
        step(0, 4'b1111, {5'd3, 5'd3, 5'd3, 5'd3});
        chk(lane_o == held, "R3 hold while disabled", 64'(lane_o), 64'(held));
        chk(punct_o == 1'b0, "R3 no puncture on held word", 64'(punct_o), 64'd0);
        step(0, 4'b1111, {5'd3, 5'd3, 5'd3, 5'd3});
        chk(lane_o == held, "R3 hold second cycle", 64'(lane_o), 64'(held));
        step(1, 4'b1100, {5'd9, 5'd10, 5'd11, 5'd12});
        check_clean(4'b1100, {5'd9, 5'd10, 5'd11, 5'd12}, "R3 resume");
    endtask

    task automatic t_sign_flip;
        step(1, 4'b1111, {5'd7, 5'd6, 5'd5, 5'd4});
        flip = '0; flip[2*WW + 6] = 1'b1;
        #1;
        chk(punct_o == 1'b1, "R5 puncture on sign flip", 64'(punct_o), 64'd1);
        chk(rx_sign_o == '0 && rx_mag_o == '0, "R5 all lanes zeroed", 64'(rx_mag_o), 64'd0);
        chk(err_o == '0, "R6 pulse not yet", 64'(err_o), 64'd0);
        step(0, 4'b1111, {5'd7, 5'd6, 5'd5, 5'd4});
        chk(err_o == 4'b0100, "R6 pulse on lane 2", 64'(err_o), 64'h4);
        flip = '0;
        #1;
        check_clean(4'b1111, {5'd7, 5'd6, 5'd5, 5'd4}, "R5 recovery");
        step(0, 4'b1111, {5'd7, 5'd6, 5'd5, 5'd4});
        chk(err_o == '0, "R6 pulse lasts one cycle", 64'(err_o), 64'd0);
    endtask

    task automatic t_multi;
        flip = '0; flip[0*WW + 5] = 1'b1; flip[3*WW + 5] = 1'b1;
        #1;
        chk(punct_o == 1'b1, "R5 puncture on redundant flips", 64'(punct_o), 64'd1);
        step(0, 4'b1111, {5'd7, 5'd6, 5'd5, 5'd4});
        chk(err_o == 4'b1001, "R6 pulses on lanes 0 and 3", 64'(err_o), 64'h9);
        flip = '0;
        step(0, 4'b1111, {5'd7, 5'd6, 5'd5, 5'd4});
        chk(err_o == '0, "R6 cleared", 64'(err_o), 64'd0);
    endtask

    task automatic t_stale;
        step(1, 4'b0110, {5'd2, 5'd20, 5'd13, 5'd27});
        ovr = lane_o;
        step(1, 4'b0110, {5'd2, 5'd20, 5'd13, 5'd27});
        use_ovr = 1'b1;
        #1;
        chk(punct_o == 1'b1, "R5 stale word detected", 64'(punct_o), 64'd1);
        chk(rx_sign_o == '0 && rx_mag_o == '0, "R5 stale zeroed", 64'(rx_mag_o), 64'd0);
        step(0, 4'b0110, {5'd2, 5'd20, 5'd13, 5'd27});
        chk(err_o == 4'b1111, "R6 stale pulses all lanes", 64'(err_o), 64'hf);
        use_ovr = 1'b0;
        #1;
        check_clean(4'b0110, {5'd2, 5'd20, 5'd13, 5'd27}, "R5 after stale");
    endtask

    task automatic t_mag;
        logic [LANES*MW-1:0] m;
        m = {5'd2, 5'd20, 5'd13, 5'd27};
        flip = '0; flip[1*WW + 0] = 1'b1;
        #1;
        chk(punct_o == 1'b0, "R7 magnitude error not punctured", 64'(punct_o), 64'd0);
        chk(rx_mag_o == (m ^ 20'(1 << MW)), "R7 corrupted magnitude passes", 64'(rx_mag_o), 64'(m ^ 20'(1 << MW)));
        step(0, 4'b0110, m);
        chk(err_o == '0, "R7 no error pulse", 64'(err_o), 64'd0);
        flip = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset;
        @(negedge clk);
        rst_n = 1'b1;
        step(0, '0, '0);
        t_reset;
        t_patterns;
        t_hold;
        t_sign_flip;
        t_multi;
        t_stale;
        t_mag;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule